// File: doc/BRIEF.md
# Presence-Only Write-Back Cache Tag Directory

This block is the tag side of a set-associative, write-back cache that allocates a line on every miss, whether the miss is a read or a write. It stores no data. For each line it keeps a valid flag, a dirty flag, the tag, the ID of the core that owns the line, the cycle on which the line was last touched, and a 6-bit saturating use count. The caller sends one command per cycle. A lookup reports hit or miss and, on a hit, updates that line's metadata. An install writes a new line into a way that an outside victim selector has chosen. The install also reports the line it pushed out, so the next level can schedule a writeback.

The victim selector reads the per-way state of any set through a registered snapshot port. That state is validity, dirtiness, owner, recency stamp and use count, which is enough for LRU, MRU, LFU or partitioned policies. Five running counters give the miss-ratio statistics: read accesses, write accesses, read misses, write misses and dirty evictions.

Top module: `wb_tag_dir`

## Requirements
- R1: A lookup hits when a valid way of the indexed set holds the address tag. The set index is address bits [OFF_W+SET_W-1:OFF_W], where OFF_W is log2 of the line size. The tag is every address bit above the index. The cycle after the command, rsp_valid is 1, and rsp_hit and rsp_way carry the result. Offset bits play no part in the match.
- R2: A lookup that misses leaves every line's metadata unchanged.
- R3: A write lookup that hits sets the line's dirty flag. A read lookup that hits leaves the dirty flag as it was.
- R4: An install makes the chosen way valid and writes its tag and owner core. It sets the use count to 0. The dirty flag becomes cmd_write, so a line filled on a write miss is dirty.
- R5: The cycle after an install, ins_done is 1 and the vic_* outputs describe the line that was replaced. vic_valid gives its validity, vic_dirty its dirty flag, vic_core its owner, and vic_addr its line address (tag and set, offset zero).
- R6: Each lookup hit adds one to the line's use count. The count stops at 63.
- R7: A cycle counter is cleared by reset and advances by one each cycle. The recency stamp of a line is loaded with the counter value seen by the command on every hit and every install.
- R8: Each lookup adds one to the read-access or write-access counter, chosen by cmd_write. A lookup that misses also adds one to the matching miss counter. Installs change none of these four counters.
- R9: The dirty-eviction counter adds one whenever an install replaces a line that is both valid and dirty.
- R10: Reset invalidates all lines, clears every counter, and drives rsp_valid, ins_done and the snapshot valid bits to 0.
- R11: The snapshot outputs show, for the set given on md_set, the state of every way as it stood before the clock edge on which they are registered. Way w sits at bit w of md_valid and md_dirty, and at slice w of md_core, md_freq and md_ts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_install | input | 1 | 0 = lookup, 1 = install |
| cmd_write | input | 1 | Lookup is a write / install line dirty |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_core | input | CORE_W | Requesting core |
| cmd_way | input | WAY_W | Way to fill on install |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Way that hit |
| ins_done | output | 1 | Install result present |
| vic_valid | output | 1 | Replaced line was valid |
| vic_dirty | output | 1 | Replaced line was dirty |
| vic_addr | output | ADDR_W | Replaced line address |
| vic_core | output | CORE_W | Replaced line owner |
| md_set | input | SET_W | Set shown on snapshot port |
| md_valid | output | NUM_WAYS | Per-way valid |
| md_dirty | output | NUM_WAYS | Per-way dirty |
| md_core | output | NUM_WAYS*CORE_W | Per-way owner |
| md_freq | output | NUM_WAYS*6 | Per-way use count |
| md_ts | output | NUM_WAYS*TS_W | Per-way recency stamp |
| stat_rd_acc | output | CNT_W | Read lookups |
| stat_wr_acc | output | CNT_W | Write lookups |
| stat_rd_miss | output | CNT_W | Read misses |
| stat_wr_miss | output | CNT_W | Write misses |
| stat_dirty_ev | output | CNT_W | Dirty lines replaced |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 64-byte lines, 8 sets, 4 ways, a 1-bit core ID and a 16-bit stamp. With only 8 sets, addresses a few kilobytes apart share a set, so tag conflicts, same-line offset hits and neighbouring-set misses are all cheap to set up. The 4 ways let the bench hold lines from two owners side by side and then replace a dirty line of each. A short 16-bit stamp keeps the expected recency values small and easy to trace. The 6-bit use count reaches saturation within a run of sixty-odd hits.

// File: rtl/tdir_pkg.sv
package tdir_pkg;
  localparam int FREQ_W = 6;
  localparam logic [FREQ_W-1:0] FREQ_MAX = '1;
endpackage

// File: rtl/tdir_way_bank.sv
module tdir_way_bank import tdir_pkg::*; #(
  parameter int SETS   = 8,
  parameter int SET_W  = 3,
  parameter int TAG_W  = 23,
  parameter int CORE_W = 1,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  acc_set,
  input  logic [SET_W-1:0]  md_set,
  input  logic              hit_en,
  input  logic              hit_wr,
  input  logic              ins_en,
  input  logic              ins_dirty,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [CORE_W-1:0] ins_core,
  input  logic [TS_W-1:0]   stamp,
  output logic              acc_valid,
  output logic              acc_dirty,
  output logic [TAG_W-1:0]  acc_tag,
  output logic [CORE_W-1:0] acc_core,
  output logic              md_valid,
  output logic              md_dirty,
  output logic [CORE_W-1:0] md_core,
  output logic [FREQ_W-1:0] md_freq,
  output logic [TS_W-1:0]   md_ts
);
  logic [SETS-1:0]   valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [CORE_W-1:0] core_mem [SETS];
  logic [TS_W-1:0]   ts_mem   [SETS];
  logic [FREQ_W-1:0] freq_mem [SETS];

  // flags need a reset, so they live in flops
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (ins_en) begin
      valid_q[acc_set] <= 1'b1;
      dirty_q[acc_set] <= ins_dirty;
    end else if (hit_en && hit_wr) begin
      dirty_q[acc_set] <= 1'b1;
    end
  end

  // payload fields: write-only-on-enable, no reset (RAM friendly)
  always_ff @(posedge clk) begin
    if (ins_en) begin
      tag_mem[acc_set]  <= ins_tag;
      core_mem[acc_set] <= ins_core;
      ts_mem[acc_set]   <= stamp;
      freq_mem[acc_set] <= '0;
    end else if (hit_en) begin
      ts_mem[acc_set] <= stamp;
      if (freq_mem[acc_set] != FREQ_MAX)
        freq_mem[acc_set] <= freq_mem[acc_set] + 1'b1;
    end
  end

  assign acc_valid = valid_q[acc_set];
  assign acc_dirty = dirty_q[acc_set];
  assign acc_tag   = tag_mem[acc_set];
  assign acc_core  = core_mem[acc_set];

  assign md_valid = valid_q[md_set];
  assign md_dirty = dirty_q[md_set];
  assign md_core  = core_mem[md_set];
  assign md_freq  = freq_mem[md_set];
  assign md_ts    = ts_mem[md_set];

  p_install_fresh_r4: assert property (@(posedge clk) disable iff (rst)
    ins_en |=> (valid_q[$past(acc_set)] && freq_mem[$past(acc_set)] == '0));

  p_hit_needs_valid_r1: assert property (@(posedge clk) disable iff (rst)
    hit_en |-> acc_valid);
endmodule

// File: rtl/tdir_match.sv
module tdir_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 23,
  parameter int WAY_W = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_valid[w] && (way_tag[w] == tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++)
      if (hit_vec[i]) hit_way = hit_way | WAY_W'(i);
  end

  p_single_match_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/tdir_stats.sv
module tdir_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_en,
  input  logic             lk_write,
  input  logic             lk_hit,
  input  logic             dirty_ev_en,
  output logic [CNT_W-1:0] rd_acc,
  output logic [CNT_W-1:0] wr_acc,
  output logic [CNT_W-1:0] rd_miss,
  output logic [CNT_W-1:0] wr_miss,
  output logic [CNT_W-1:0] dirty_ev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_acc   <= '0;
      wr_acc   <= '0;
      rd_miss  <= '0;
      wr_miss  <= '0;
      dirty_ev <= '0;
    end else begin
      if (lk_en && !lk_write) rd_acc <= rd_acc + 1'b1;
      if (lk_en &&  lk_write) wr_acc <= wr_acc + 1'b1;
      if (lk_en && !lk_write && !lk_hit) rd_miss <= rd_miss + 1'b1;
      if (lk_en &&  lk_write && !lk_hit) wr_miss <= wr_miss + 1'b1;
      if (dirty_ev_en) dirty_ev <= dirty_ev + 1'b1;
    end
  end

  p_miss_bounded_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_miss <= rd_acc) && (wr_miss <= wr_acc));

  p_dirty_ev_step_r9: assert property (@(posedge clk) disable iff (rst)
    (dirty_ev == $past(dirty_ev)) || (dirty_ev == CNT_W'($past(dirty_ev) + 1'b1)));
endmodule

// File: rtl/wb_tag_dir.sv
module wb_tag_dir import tdir_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_SETS   = 8,
  parameter int NUM_WAYS   = 4,
  parameter int CORE_W     = 1,
  parameter int TS_W       = 16,
  parameter int CNT_W      = 16,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  input  logic                       cmd_install,
  input  logic                       cmd_write,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic [CORE_W-1:0]          cmd_core,
  input  logic [WAY_W-1:0]           cmd_way,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic [WAY_W-1:0]           rsp_way,
  output logic                       ins_done,
  output logic                       vic_valid,
  output logic                       vic_dirty,
  output logic [ADDR_W-1:0]          vic_addr,
  output logic [CORE_W-1:0]          vic_core,
  input  logic [SET_W-1:0]           md_set,
  output logic [NUM_WAYS-1:0]        md_valid,
  output logic [NUM_WAYS-1:0]        md_dirty,
  output logic [NUM_WAYS*CORE_W-1:0] md_core,
  output logic [NUM_WAYS*FREQ_W-1:0] md_freq,
  output logic [NUM_WAYS*TS_W-1:0]   md_ts,
  output logic [CNT_W-1:0]           stat_rd_acc,
  output logic [CNT_W-1:0]           stat_wr_acc,
  output logic [CNT_W-1:0]           stat_rd_miss,
  output logic [CNT_W-1:0]           stat_wr_miss,
  output logic [CNT_W-1:0]           stat_dirty_ev
);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic             addr_unused_bits;
  logic             do_lookup, do_install;
  logic [TS_W-1:0]  cyc_q;

  assign set_idx          = cmd_addr[OFF_W +: SET_W];
  assign tag              = cmd_addr[ADDR_W-1 -: TAG_W];
  assign addr_unused_bits = ^cmd_addr[OFF_W-1:0];
  assign do_lookup        = cmd_valid && !cmd_install;
  assign do_install       = cmd_valid &&  cmd_install;

  always_ff @(posedge clk) begin
    if (rst) cyc_q <= '0;
    else     cyc_q <= cyc_q + 1'b1;
  end

  logic [NUM_WAYS-1:0]              acc_valid_w, acc_dirty_w, hit_vec;
  logic [NUM_WAYS-1:0][TAG_W-1:0]   acc_tag_w;
  logic [NUM_WAYS-1:0][CORE_W-1:0]  acc_core_w;
  logic [NUM_WAYS-1:0]              md_valid_w, md_dirty_w;
  logic [NUM_WAYS*CORE_W-1:0]       md_core_w;
  logic [NUM_WAYS*FREQ_W-1:0]       md_freq_w;
  logic [NUM_WAYS*TS_W-1:0]         md_ts_w;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tdir_way_bank #(
      .SETS(NUM_SETS), .SET_W(SET_W), .TAG_W(TAG_W),
      .CORE_W(CORE_W), .TS_W(TS_W)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .acc_set   (set_idx),
      .md_set    (md_set),
      .hit_en    (do_lookup && hit_vec[w]),
      .hit_wr    (cmd_write),
      .ins_en    (do_install && (cmd_way == WAY_W'(w))),
      .ins_dirty (cmd_write),
      .ins_tag   (tag),
      .ins_core  (cmd_core),
      .stamp     (cyc_q),
      .acc_valid (acc_valid_w[w]),
      .acc_dirty (acc_dirty_w[w]),
      .acc_tag   (acc_tag_w[w]),
      .acc_core  (acc_core_w[w]),
      .md_valid  (md_valid_w[w]),
      .md_dirty  (md_dirty_w[w]),
      .md_core   (md_core_w[w*CORE_W +: CORE_W]),
      .md_freq   (md_freq_w[w*FREQ_W +: FREQ_W]),
      .md_ts     (md_ts_w[w*TS_W +: TS_W])
    );
  end

  logic             hit_any;
  logic [WAY_W-1:0] hit_way;

  tdir_match #(.WAYS(NUM_WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .way_valid (acc_valid_w),
    .way_tag   (acc_tag_w),
    .tag       (tag),
    .hit_vec   (hit_vec),
    .hit       (hit_any),
    .hit_way   (hit_way)
  );

  // displaced line of the way being filled
  logic              old_valid, old_dirty;
  logic [TAG_W-1:0]  old_tag;
  logic [CORE_W-1:0] old_core;
  assign old_valid = acc_valid_w[cmd_way];
  assign old_dirty = acc_dirty_w[cmd_way];
  assign old_tag   = acc_tag_w[cmd_way];
  assign old_core  = acc_core_w[cmd_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      ins_done  <= 1'b0;
      vic_valid <= 1'b0;
      vic_dirty <= 1'b0;
      vic_addr  <= '0;
      vic_core  <= '0;
      md_valid  <= '0;
      md_dirty  <= '0;
      md_core   <= '0;
      md_freq   <= '0;
      md_ts     <= '0;
    end else begin
      rsp_valid <= do_lookup;
      rsp_hit   <= do_lookup && hit_any;
      rsp_way   <= hit_way;
      ins_done  <= do_install;
      if (do_install) begin
        vic_valid <= old_valid;
        vic_dirty <= old_valid && old_dirty;
        vic_addr  <= {old_tag, set_idx, {OFF_W{1'b0}}};
        vic_core  <= old_core;
      end
      md_valid <= md_valid_w;
      md_dirty <= md_dirty_w;
      md_core  <= md_core_w;
      md_freq  <= md_freq_w;
      md_ts    <= md_ts_w;
    end
  end

  tdir_stats #(.CNT_W(CNT_W)) u_stats (
    .clk         (clk),
    .rst         (rst),
    .lk_en       (do_lookup),
    .lk_write    (cmd_write),
    .lk_hit      (hit_any),
    .dirty_ev_en (do_install && old_valid && old_dirty),
    .rd_acc      (stat_rd_acc),
    .wr_acc      (stat_wr_acc),
    .rd_miss     (stat_rd_miss),
    .wr_miss     (stat_wr_miss),
    .dirty_ev    (stat_dirty_ev)
  );

  p_rsp_follows_lookup_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(cmd_valid && !cmd_install));

  p_vic_dirty_implies_valid_r5: assert property (@(posedge clk) disable iff (rst)
    ins_done |-> (vic_valid || !vic_dirty));

  p_stamp_step_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cyc_q == TS_W'($past(cyc_q) + 1'b1)));

  p_dirty_ev_on_install_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_dirty_ev != $past(stat_dirty_ev)) |-> (ins_done && vic_dirty));
endmodule

// File: tb/test_wb_tag_dir.sv
`timescale 1ns/1ps
module test_wb_tag_dir;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_install = 1'b0, cmd_write = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic        cmd_core = 1'b0;
  logic [1:0]  cmd_way = '0;
  logic        rsp_valid, rsp_hit, ins_done, vic_valid, vic_dirty, vic_core;
  logic [1:0]  rsp_way;
  logic [31:0] vic_addr;
  logic [2:0]  md_set = '0;
  logic [3:0]  md_valid, md_dirty, md_core;
  logic [23:0] md_freq;
  logic [63:0] md_ts;
  logic [15:0] s_rd, s_wr, s_rdm, s_wrm, s_dev;

  always #5 clk = ~clk;

  wb_tag_dir i_wb_tag_dir (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_install(cmd_install),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_core(cmd_core), .cmd_way(cmd_way),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .ins_done(ins_done), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
    .vic_addr(vic_addr), .vic_core(vic_core), .md_set(md_set),
    .md_valid(md_valid), .md_dirty(md_dirty), .md_core(md_core),
    .md_freq(md_freq), .md_ts(md_ts),
    .stat_rd_acc(s_rd), .stat_wr_acc(s_wr), .stat_rd_miss(s_rdm),
    .stat_wr_miss(s_wrm), .stat_dirty_ev(s_dev)
  );

  // model of the R7 cycle counter: cleared by reset, +1 per cycle
  logic [15:0] bcyc = '0;
  always @(posedge clk) bcyc <= rst ? 16'd0 : bcyc + 16'd1;

  int total = 0, bad = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic inst, input logic wr, input logic core,
                       input logic [31:0] addr, input logic [1:0] way);
    cmd_valid = 1'b1; cmd_install = inst; cmd_write = wr;
    cmd_core = core; cmd_addr = addr; cmd_way = way;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic peek(input logic [2:0] s);
    md_set = s;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic inst; logic wr; logic core; logic [31:0] addr; logic [1:0] way;
    logic hit; logic vv; logic vd; logic [31:0] vaddr; logic vcore;
  } vec_t;

  // set 2 traffic: tag1=0x480, tag2=0x880, tag3=0xC80, tag4=0x1080
  localparam vec_t VEC [12] = '{
    '{1'b0,1'b0,1'b0,32'h480 ,2'd0,1'b0,1'b0,1'b0,32'h0  ,1'b0},
    '{1'b1,1'b0,1'b0,32'h480 ,2'd0,1'b0,1'b0,1'b0,32'h0  ,1'b0},
    '{1'b0,1'b0,1'b0,32'h480 ,2'd0,1'b1,1'b0,1'b0,32'h0  ,1'b0},
    '{1'b0,1'b1,1'b1,32'h880 ,2'd0,1'b0,1'b0,1'b0,32'h0  ,1'b0},
    '{1'b1,1'b1,1'b1,32'h880 ,2'd1,1'b0,1'b0,1'b0,32'h0  ,1'b0},
    '{1'b0,1'b1,1'b0,32'h480 ,2'd0,1'b1,1'b0,1'b0,32'h0  ,1'b0},
    '{1'b0,1'b0,1'b0,32'h488 ,2'd0,1'b1,1'b0,1'b0,32'h0  ,1'b0},
    '{1'b0,1'b0,1'b0,32'hC80 ,2'd0,1'b0,1'b0,1'b0,32'h0  ,1'b0},
    '{1'b1,1'b0,1'b0,32'hC80 ,2'd0,1'b0,1'b1,1'b1,32'h480,1'b0},
    '{1'b0,1'b0,1'b0,32'h480 ,2'd0,1'b0,1'b0,1'b0,32'h0  ,1'b0},
    '{1'b0,1'b0,1'b0,32'h4C0 ,2'd0,1'b0,1'b0,1'b0,32'h0  ,1'b0},
    '{1'b1,1'b0,1'b0,32'h1080,2'd1,1'b0,1'b1,1'b1,32'h880,1'b1}
  };

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL R1 watchdog expired act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] ts_exp;
    repeat (3) @(negedge clk);
    // R10: state during reset
    chk("R10 rsp_valid", rsp_valid, 0);
    chk("R10 ins_done", ins_done, 0);
    chk("R10 md_valid", md_valid, 0);
    chk("R10 rd_acc", s_rd, 0);
    chk("R10 dirty_ev", s_dev, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R3 R5 R8: vector walk in set 2
    for (int i = 0; i < 12; i++) begin
      issue(VEC[i].inst, VEC[i].wr, VEC[i].core, VEC[i].addr, VEC[i].way);
      if (!VEC[i].inst) begin
        chk($sformatf("R1 vec%0d rsp_valid", i), rsp_valid, 1);
        chk($sformatf("R1 vec%0d rsp_hit", i), rsp_hit, VEC[i].hit);
        if (VEC[i].hit) chk($sformatf("R1 vec%0d rsp_way", i), rsp_way, VEC[i].way);
      end else begin
        chk($sformatf("R5 vec%0d ins_done", i), ins_done, 1);
        chk($sformatf("R5 vec%0d vic_valid", i), vic_valid, VEC[i].vv);
        if (VEC[i].vv) begin
          chk($sformatf("R3 vec%0d vic_dirty", i), vic_dirty, VEC[i].vd);
          chk($sformatf("R5 vec%0d vic_addr", i), vic_addr, VEC[i].vaddr);
          chk($sformatf("R5 vec%0d vic_core", i), vic_core, VEC[i].vcore);
        end
      end
    end
    chk("R8 rd_acc", s_rd, 6);
    chk("R8 wr_acc", s_wr, 2);
    chk("R8 rd_miss", s_rdm, 4);
    chk("R8 wr_miss", s_wrm, 1);
    chk("R9 dirty_ev", s_dev, 2);

    // R4 R11: set 2 snapshot after refills (ways 0,1 clean, owner 0)
    peek(3'd2);
    chk("R11 md_valid set2", md_valid, 4'b0011);
    chk("R4 md_dirty set2", md_dirty, 4'b0000);
    chk("R4 md_core way1", md_core[1], 0);
    chk("R4 md_freq way0", md_freq[0 +: 6], 0);

    // R4 R7: fresh install into set 5 way 2, core 1, clean
    ts_exp = bcyc;
    issue(1'b1, 1'b0, 1'b1, 32'h340, 2'd2);
    chk("R5 empty way vic_valid", vic_valid, 0);
    peek(3'd5);
    chk("R11 md_valid set5", md_valid, 4'b0100);
    chk("R4 md_core way2", md_core[2], 1);
    chk("R4 md_freq way2", md_freq[12 +: 6], 0);
    chk("R7 md_ts install", md_ts[32 +: 16], ts_exp);

    // R6 R3 R7: three read hits
    for (int k = 0; k < 3; k++) begin
      ts_exp = bcyc;
      issue(1'b0, 1'b0, 1'b0, 32'h340, 2'd0);
    end
    peek(3'd5);
    chk("R6 md_freq after 3 hits", md_freq[12 +: 6], 3);
    chk("R3 read hit keeps clean", md_dirty[2], 0);
    chk("R7 md_ts hit", md_ts[32 +: 16], ts_exp);

    issue(1'b0, 1'b1, 1'b0, 32'h340, 2'd0);
    peek(3'd5);
    chk("R3 write hit sets dirty", md_dirty[2], 1);
    chk("R6 md_freq after 4 hits", md_freq[12 +: 6], 4);

    // R6: saturation at 63
    for (int k = 0; k < 66; k++) begin
      ts_exp = bcyc;
      issue(1'b0, 1'b0, 1'b0, 32'h340, 2'd0);
    end
    peek(3'd5);
    chk("R6 md_freq saturated", md_freq[12 +: 6], 63);

    // R2: miss in set 5 changes nothing
    issue(1'b0, 1'b1, 1'b1, 32'h1340, 2'd0);
    chk("R2 miss rsp_hit", rsp_hit, 0);
    peek(3'd5);
    chk("R2 md_valid kept", md_valid, 4'b0100);
    chk("R2 md_ts kept", md_ts[32 +: 16], ts_exp);
    chk("R2 md_freq kept", md_freq[12 +: 6], 63);
    chk("R2 md_dirty kept", md_dirty, 4'b0100);

    // R10: reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    peek(3'd5);
    chk("R10 md_valid after reset", md_valid, 0);
    chk("R10 rd_acc after reset", s_rd, 0);
    chk("R10 wr_miss after reset", s_wrm, 0);
    issue(1'b0, 1'b0, 1'b0, 32'h340, 2'd0);
    chk("R10 lookup misses after reset", rsp_hit, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule